// File: doc/BRIEF.md
# Snooping Three-State Coherence Controller

This block keeps one small direct-mapped, write-back data cache coherent with its peers on a shared snooping bus. Each line holds one data word, a tag and one of three coherence states: Invalid, Shared (clean and readable) or Exclusive (the only copy, writable and dirty). Local loads and stores that hit are served at once. Every other access first wins the bus and then issues a read-miss or write-miss transaction. A dirty line that conflicts with the new address is written back before the miss is issued.

The controller also watches the transactions that other caches place on the bus. A snooped write miss removes the local copy. A snooped read miss to a dirty line demotes it to Shared. In both cases a dirty line is supplied on the flush outputs so that memory and the requester see the latest value. The bus carries one transaction at a time. A grant is a single-cycle transfer in which the memory side returns fill data in the same cycle. Snoops are never presented in a grant cycle.

Top module: `snoop_msi_ctrl`

## Requirements
- R1: After reset every line is Invalid, and cpuBusy, cpuDone, busReq and snpFlush are all low.
- R2: A load whose line is Invalid or holds another tag issues a read miss (busCmd 1, address = request address). On its grant the line becomes Shared with busFillData as its word, and cpuRdata returns that word.
- R3: A load to a Shared or Exclusive line with a matching tag, or a store to an Exclusive line with a matching tag, raises cpuDone for one cycle, one cycle after acceptance, and never requests the bus. cpuRdata returns the word read, or the word written.
- R4: A store to a line that is Shared with a matching tag, or that misses, issues a write miss (busCmd 2). On its grant the line becomes Exclusive holding the store data.
- R5: When the line selected by a missing request is Exclusive under a different tag, a write-back (busCmd 3) carrying that line's address and word is granted first, and only then the miss.
- R6: cpuBusy is high while a miss waits for or performs bus transactions, and busReq stays asserted until busGnt. cpuDone follows one cycle after the grant of the read or write miss.
- R7: A snooped read miss (snpCmd 1) that matches an Exclusive line raises snpFlush with the line's word in the following cycle and leaves the line Shared.
- R8: A snooped write miss (snpCmd 2) that matches a Shared or Exclusive line makes it Invalid. An Exclusive line is also flushed in the following cycle.
- R9: Snoops whose tag does not match, that target an Invalid line, or that carry a write-back (snpCmd 3) change neither line state nor data, and raise no flush.
- R10: Once another cache has written an address through a write miss, this cache no longer holds it Exclusive, so the next local store to it needs a write miss. The line index is the low log2(LINES) address bits; the tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpuReq | input | 1 | Processor request, held until cpuDone |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Request word address |
| cpuWdata | input | DATA_W | Store data |
| cpuBusy | output | 1 | Request stalled on the bus |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | DATA_W | Loaded or stored word |
| busReq | output | 1 | Bus arbitration request |
| busGnt | input | 1 | Grant; the transaction completes in this cycle |
| busCmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| busAddr | output | ADDR_W | Transaction address |
| busData | output | DATA_W | Write-back data |
| busFillData | input | DATA_W | Fill word returned in the grant cycle |
| snpValid | input | 1 | Another cache's transaction is on the bus |
| snpCmd | input | 2 | Snooped command, same encoding as busCmd |
| snpAddr | input | ADDR_W | Snooped address |
| snpFlush | output | 1 | Dirty word supplied for the snooped miss |
| snpData | output | DATA_W | Supplied word |

## Verification
Hits produce cpuDone exactly one cycle after the request is accepted. The bench counts this as a latency of one sampling point and requires that no grant was ever given. For misses, the completion is due one cycle after the last grant, and a write-back grant is followed the next cycle by the miss request. The bench grants two cycles after it sees a request, logs every granted command in order, and checks that cpuBusy is high while it waits. Snoop responses are due one cycle after the snoop is driven. The bench samples snpFlush at that single point, and then probes the resulting line state with a later load or store whose bus traffic reveals whether the line was Invalid, Shared or Exclusive.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } lineState_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WRBACK = 2'd3
  } busCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selLatched;  // look up the captured request instead of the port
    logic capture;     // latch the processor request
    logic hitRead;     // load hit: return line word
    logic hitWrite;    // store hit: update line word
    logic fill;        // miss granted: install line
    logic victimInv;   // write-back granted: drop victim
    logic wbSel;       // bus address/data come from the victim
    logic snpDown;     // snooped read miss on dirty line
    logic snpInv;      // snooped write miss on valid line
    logic snpFlush;    // supply dirty word next cycle
  } dpStrobe_t;

endpackage

// File: rtl/msi_datapath.sv
module msi_datapath
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] busFillData,
  output lineState_e        lkState,
  output logic              lkTagMatch,
  output logic              reqWe,
  output lineState_e        snState,
  output logic              snTagMatch,
  output logic              sameIdx,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] rdata,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpData
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_e        stateQ [LINES];
  logic [TAG_W-1:0]  tagQ   [LINES];
  logic [DATA_W-1:0] dataQ  [LINES];

  logic [ADDR_W-1:0] reqAddrQ;
  logic [DATA_W-1:0] reqWdataQ;
  logic              reqWeQ;
  logic [DATA_W-1:0] rdataQ;
  logic              flushQ;
  logic [DATA_W-1:0] flushDataQ;

  logic [ADDR_W-1:0] lkAddr;
  logic [IDX_W-1:0]  lkIdx, snIdx;
  logic [TAG_W-1:0]  lkTag, snTag;
  logic [DATA_W-1:0] fillWord;

  always_comb begin
    lkAddr     = stb.selLatched ? reqAddrQ : cpuAddr;
    lkIdx      = lkAddr[IDX_W-1:0];
    lkTag      = lkAddr[ADDR_W-1:IDX_W];
    snIdx      = snpAddr[IDX_W-1:0];
    snTag      = snpAddr[ADDR_W-1:IDX_W];
    lkState    = stateQ[lkIdx];
    lkTagMatch = (tagQ[lkIdx] == lkTag);
    snState    = stateQ[snIdx];
    snTagMatch = (tagQ[snIdx] == snTag);
    sameIdx    = (snIdx == cpuAddr[IDX_W-1:0]);
    fillWord   = reqWeQ ? reqWdataQ : busFillData;
    busAddr    = stb.wbSel ? {tagQ[lkIdx], lkIdx} : reqAddrQ;
    busData    = dataQ[lkIdx];
  end

  // line array
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        stateQ[i] <= LS_INV;
        tagQ[i]   <= '0;
        dataQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (lkIdx == IDX_W'(i)) begin
          if (stb.fill) begin
            stateQ[i] <= reqWeQ ? LS_EXC : LS_SHR;
            tagQ[i]   <= lkTag;
            dataQ[i]  <= fillWord;
          end else if (stb.victimInv) begin
            stateQ[i] <= LS_INV;
          end else if (stb.hitWrite) begin
            dataQ[i]  <= cpuWdata;
          end
        end
        if (snIdx == IDX_W'(i)) begin
          if (stb.snpInv)       stateQ[i] <= LS_INV;
          else if (stb.snpDown) stateQ[i] <= LS_SHR;
        end
      end
    end
  end

  // request latch, response and flush registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqAddrQ   <= '0;
      reqWdataQ  <= '0;
      reqWeQ     <= 1'b0;
      rdataQ     <= '0;
      flushQ     <= 1'b0;
      flushDataQ <= '0;
    end else begin
      if (stb.capture) begin
        reqAddrQ  <= cpuAddr;
        reqWdataQ <= cpuWdata;
        reqWeQ    <= cpuWe;
      end
      if (stb.hitRead)       rdataQ <= dataQ[lkIdx];
      else if (stb.hitWrite) rdataQ <= cpuWdata;
      else if (stb.fill)     rdataQ <= fillWord;
      flushQ <= stb.snpFlush;
      if (stb.snpFlush) flushDataQ <= dataQ[snIdx];
    end
  end

  assign reqWe    = reqWeQ;
  assign rdata    = rdataQ;
  assign snpFlush = flushQ;
  assign snpData  = flushDataQ;

endmodule

// File: rtl/msi_control.sv
module msi_control
  import msi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       snpValid,
  input  logic [1:0] snpCmd,
  input  logic       busGnt,
  input  lineState_e lkState,
  input  logic       lkTagMatch,
  input  logic       reqWe,
  input  lineState_e snState,
  input  logic       snTagMatch,
  input  logic       sameIdx,
  output dpStrobe_t  stb,
  output logic       busReq,
  output logic [1:0] busCmd,
  output logic       cpuBusy,
  output logic       cpuDone
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_RESP} ctlState_e;

  ctlState_e stQ, stNxt;
  busCmd_e   cmd;
  logic      snpHit, cpuHit, dirtyVictim;

  always_comb begin
    stb         = '0;
    stNxt       = stQ;
    cmd         = BC_NONE;
    cpuHit      = 1'b0;
    dirtyVictim = 1'b0;

    // snoop side
    snpHit = snpValid && snTagMatch && (snState != LS_INV);
    if (snpHit && busCmd_e'(snpCmd) == BC_WRMISS) begin
      stb.snpInv   = 1'b1;
      stb.snpFlush = (snState == LS_EXC);
    end else if (snpHit && busCmd_e'(snpCmd) == BC_RDMISS && snState == LS_EXC) begin
      stb.snpDown  = 1'b1;
      stb.snpFlush = 1'b1;
    end

    // processor side
    unique case (stQ)
      ST_IDLE: begin
        if (cpuReq && !(snpValid && sameIdx)) begin
          cpuHit = lkTagMatch && (cpuWe ? (lkState == LS_EXC) : (lkState != LS_INV));
          if (cpuHit) begin
            stb.hitWrite = cpuWe;
            stb.hitRead  = !cpuWe;
          end else begin
            stb.capture  = 1'b1;
          end
          stNxt = cpuHit ? ST_RESP : ST_BUS;
        end
      end
      ST_BUS: begin
        stb.selLatched = 1'b1;
        dirtyVictim    = (lkState == LS_EXC) && !lkTagMatch;
        stb.wbSel      = dirtyVictim;
        cmd            = dirtyVictim ? BC_WRBACK : (reqWe ? BC_WRMISS : BC_RDMISS);
        if (busGnt) begin
          if (dirtyVictim) begin
            stb.victimInv = 1'b1;
          end else begin
            stb.fill = 1'b1;
            stNxt    = ST_RESP;
          end
        end
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stQ <= ST_IDLE;
    else        stQ <= stNxt;
  end

  assign busReq  = (stQ == ST_BUS);
  assign busCmd  = cmd;
  assign cpuBusy = (stQ == ST_BUS);
  assign cpuDone = (stQ == ST_RESP);

endmodule

// File: rtl/snoop_msi_ctrl.sv
module snoop_msi_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuBusy,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGnt,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  input  logic [DATA_W-1:0] busFillData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpData
);
  dpStrobe_t  stb;
  lineState_e lkState, snState;
  logic       lkTagMatch, snTagMatch, reqWe, sameIdx;

  msi_control u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpuReq     (cpuReq),
    .cpuWe      (cpuWe),
    .snpValid   (snpValid),
    .snpCmd     (snpCmd),
    .busGnt     (busGnt),
    .lkState    (lkState),
    .lkTagMatch (lkTagMatch),
    .reqWe      (reqWe),
    .snState    (snState),
    .snTagMatch (snTagMatch),
    .sameIdx    (sameIdx),
    .stb        (stb),
    .busReq     (busReq),
    .busCmd     (busCmd),
    .cpuBusy    (cpuBusy),
    .cpuDone    (cpuDone)
  );

  msi_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .cpuAddr     (cpuAddr),
    .cpuWe       (cpuWe),
    .cpuWdata    (cpuWdata),
    .snpAddr     (snpAddr),
    .busFillData (busFillData),
    .lkState     (lkState),
    .lkTagMatch  (lkTagMatch),
    .reqWe       (reqWe),
    .snState     (snState),
    .snTagMatch  (snTagMatch),
    .sameIdx     (sameIdx),
    .busAddr     (busAddr),
    .busData     (busData),
    .rdata       (cpuRdata),
    .snpFlush    (snpFlush),
    .snpData     (snpData)
  );

endmodule

// File: rtl/snoop_msi_ctrl_chk.sv
module snoop_msi_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpuBusy,
  input logic       cpuDone,
  input logic       busReq,
  input logic       busGnt,
  input logic [1:0] busCmd,
  input logic       snpValid,
  input logic       snpFlush
);
  // R7 / R8: a flush only answers a snoop of the previous cycle
  assert_flush_follows_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snpFlush |-> $past(snpValid));

  // R6: a stalled processor always has a live bus request
  assert_busy_requests_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpuBusy |-> (busReq && busCmd != 2'd0));

  // R6: completion one cycle after the granted miss
  assert_miss_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq && busGnt && (busCmd == 2'd1 || busCmd == 2'd2)) |=> cpuDone);

  // R5: a granted write-back is followed by the miss itself
  assert_wb_then_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq && busGnt && busCmd == 2'd3) |=> (busReq && (busCmd == 2'd1 || busCmd == 2'd2)));

  // R3: completion is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpuDone |=> !cpuDone);

endmodule

bind snoop_msi_ctrl snoop_msi_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpuBusy  (cpuBusy),
  .cpuDone  (cpuDone),
  .busReq   (busReq),
  .busGnt   (busGnt),
  .busCmd   (busCmd),
  .snpValid (snpValid),
  .snpFlush (snpFlush)
);

// File: tb/snoop_msi_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_msi_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [7:0]  cpuAddr = '0;
  logic [15:0] cpuWdata = '0;
  logic        cpuBusy, cpuDone;
  logic [15:0] cpuRdata;
  logic        busReq;
  logic        busGnt = 1'b0;
  logic [1:0]  busCmd;
  logic [7:0]  busAddr;
  logic [15:0] busData;
  logic [15:0] busFillData = '0;
  logic        snpValid = 1'b0;
  logic [1:0]  snpCmd = '0;
  logic [7:0]  snpAddr = '0;
  logic        snpFlush;
  logic [15:0] snpData;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] mem [256];

  always #2 clk = ~clk;

  snoop_msi_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuBusy(cpuBusy), .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .busReq(busReq), .busGnt(busGnt), .busCmd(busCmd), .busAddr(busAddr),
    .busData(busData), .busFillData(busFillData),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpFlush(snpFlush), .snpData(snpData)
  );

  function automatic logic [15:0] memInit(input logic [7:0] a);
    return 16'h1000 + 16'(a) * 16'd7;
  endfunction

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [1:0]  c1;
    logic [1:0]  c2;
    logic [15:0] rd;
  } vec_t;

  localparam logic [15:0] VA = 16'hAAAA, VB = 16'hB00B, VC = 16'hC0C0;

  // cmd codes: 0 none, 1 read miss, 2 write miss, 3 write-back
  localparam vec_t VEC [9] = '{
    '{1'b0, 8'h10, 16'h0, 2'd1, 2'd0, memInit(8'h10)},  // cold load
    '{1'b0, 8'h10, 16'h0, 2'd0, 2'd0, memInit(8'h10)},  // load hit Shared
    '{1'b1, 8'h10, VA,    2'd2, 2'd0, VA},              // store to Shared
    '{1'b0, 8'h10, 16'h0, 2'd0, 2'd0, VA},              // load hit Exclusive
    '{1'b1, 8'h10, VB,    2'd0, 2'd0, VB},              // store hit Exclusive
    '{1'b0, 8'h14, 16'h0, 2'd3, 2'd1, memInit(8'h14)},  // dirty conflict
    '{1'b0, 8'h10, 16'h0, 2'd1, 2'd0, VB},              // written-back word
    '{1'b1, 8'h21, VC,    2'd2, 2'd0, VC},              // store miss
    '{1'b0, 8'h21, 16'h0, 2'd0, 2'd0, VC}               // load hit
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one processor access, acting as bus arbiter and memory
  task automatic doOp(input logic we, input logic [7:0] addr, input logic [15:0] wdata,
                      output logic [1:0] c1, output logic [1:0] c2,
                      output logic [7:0] a1, output logic [15:0] d1,
                      output logic [15:0] rd, output int lat, output bit busyOk);
    int nG = 0;
    int wcnt = 0;
    logic [1:0] lastCmd = 2'd0;
    logic [7:0] lastAddr = '0;
    logic [15:0] lastData = '0;
    bit finished = 0;
    c1 = 2'd0; c2 = 2'd0; a1 = '0; d1 = '0; rd = '0; lat = 0; busyOk = 1;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wdata;
    for (int k = 0; k < 60 && !finished; k++) begin
      @(negedge clk);
      lat++;
      if (busGnt) begin
        busGnt = 1'b0;
        if (lastCmd == 2'd3) mem[lastAddr] = lastData;
      end
      if (cpuDone) begin
        rd = cpuRdata;
        finished = 1;
      end else if (busReq) begin
        if (!cpuBusy) busyOk = 0;
        wcnt++;
        if (wcnt == 2) begin
          busGnt = 1'b1;
          busFillData = mem[busAddr];
          lastCmd = busCmd; lastAddr = busAddr; lastData = busData;
          if (nG == 0) begin c1 = busCmd; a1 = busAddr; d1 = busData; end
          else if (nG == 1) c2 = busCmd;
          nG++;
          wcnt = 0;
        end
      end
    end
    cpuReq = 1'b0;
    if (!finished) check(1'b0, "watchdog access timeout", 16'(lat), 16'd0);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [7:0] addr,
                       input bit expFlush, input logic [15:0] expData, input string req);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = cmd; snpAddr = addr;
    @(negedge clk);
    snpValid = 1'b0;
    check(snpFlush == expFlush, req, 16'(snpFlush), 16'(expFlush));
    if (expFlush && snpFlush) begin
      check(snpData == expData, req, snpData, expData);
      mem[addr] = snpData;
    end
  endtask

  // processor op with full check of the bus trace
  task automatic opCheck(input logic we, input logic [7:0] addr, input logic [15:0] wdata,
                         input logic [1:0] e1, input logic [1:0] e2,
                         input logic [15:0] erd, input string req);
    logic [1:0] c1, c2;
    logic [7:0] a1;
    logic [15:0] d1, rd;
    int lat;
    bit busyOk;
    doOp(we, addr, wdata, c1, c2, a1, d1, rd, lat, busyOk);
    check(c1 == e1 && c2 == e2, req, {12'h0, c1, c2}, {12'h0, e1, e2});
    check(rd == erd, req, rd, erd);
    if (e1 == 2'd0) check(lat == 1, {req, " R3 latency"}, 16'(lat), 16'd1);
    else            check(busyOk, {req, " R6 busy"}, 16'(busyOk), 16'd1);
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog global", 16'd0, 16'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [1:0] c1, c2;
    logic [7:0] a1;
    logic [15:0] d1, rd;
    int lat;
    bit busyOk;
    string tag;
    for (int i = 0; i < 256; i++) mem[i] = memInit(8'(i));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!cpuBusy && !cpuDone && !busReq && !snpFlush, "R1 reset outputs",
          {12'h0, cpuBusy, cpuDone, busReq, snpFlush}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busReq && !cpuDone, "R1 idle after reset", {14'h0, busReq, cpuDone}, 16'h0);

    // table of accesses
    for (int i = 0; i < 9; i++) begin
      doOp(VEC[i].we, VEC[i].addr, VEC[i].wdata, c1, c2, a1, d1, rd, lat, busyOk);
      case (VEC[i].c1)
        2'd0: tag = "R3 hit";
        2'd1: tag = "R2 read miss";
        2'd2: tag = "R4 write miss";
        default: tag = "R5 write-back";
      endcase
      check(c1 == VEC[i].c1 && c2 == VEC[i].c2, tag, {12'h0, c1, c2}, {12'h0, VEC[i].c1, VEC[i].c2});
      check(rd == VEC[i].rd, tag, rd, VEC[i].rd);
      if (VEC[i].c1 == 2'd0) check(lat == 1, "R3 hit latency", 16'(lat), 16'd1);
      else                   check(busyOk, "R6 busy while waiting", 16'(busyOk), 16'd1);
      if (VEC[i].c1 == 2'd3) begin
        check(a1 == 8'h10, "R5 victim address", 16'(a1), 16'h0010);
        check(d1 == VB, "R5 victim data", d1, VB);
      end
    end

    // R7: snooped read miss on dirty line, then a store must upgrade
    snoop(2'd1, 8'h21, 1'b1, VC, "R7 flush on read miss");
    opCheck(1'b1, 8'h21, 16'hD00D, 2'd2, 2'd0, 16'hD00D, "R7 line now Shared");
    // R8: snooped write miss on dirty line
    snoop(2'd2, 8'h21, 1'b1, 16'hD00D, "R8 flush on write miss");
    // R10: another cache owns it now; local store cannot hit
    opCheck(1'b1, 8'h21, 16'hE1E1, 2'd2, 2'd0, 16'hE1E1, "R10 single owner");
    opCheck(1'b0, 8'h21, 16'h0, 2'd0, 2'd0, 16'hE1E1, "R3 load hit Exclusive");
    snoop(2'd2, 8'h21, 1'b1, 16'hE1E1, "R8 flush Exclusive");
    opCheck(1'b0, 8'h21, 16'h0, 2'd1, 2'd0, 16'hE1E1, "R8 line Invalid after snoop");
    // R9: ignored snoops on a Shared line
    snoop(2'd1, 8'h25, 1'b0, 16'h0, "R9 other tag");
    snoop(2'd2, 8'h25, 1'b0, 16'h0, "R9 other tag write miss");
    snoop(2'd3, 8'h21, 1'b0, 16'h0, "R9 write-back snoop");
    snoop(2'd1, 8'h21, 1'b0, 16'h0, "R9 read miss on Shared");
    opCheck(1'b0, 8'h21, 16'h0, 2'd0, 2'd0, 16'hE1E1, "R9 line kept");
    // R8: write miss invalidates a Shared line without flush
    snoop(2'd2, 8'h21, 1'b0, 16'h0, "R8 Shared no flush");
    opCheck(1'b0, 8'h21, 16'h0, 2'd1, 2'd0, 16'hE1E1, "R8 Shared invalidated");
    // R9: snoop to an Invalid line
    snoop(2'd2, 8'h13, 1'b0, 16'h0, "R9 Invalid line");
    opCheck(1'b0, 8'h13, 16'h0, 2'd1, 2'd0, memInit(8'h13), "R2 cold line");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule